// File: doc/BRIEF.md
# Interleaved Two-Channel PWM Burst Sequencer

This block drives two single-slope PWM outputs from one shared free-running counter. The counter advances only on cycles where the timebase tick enable is high. It wraps after its active top count, so a top value of P gives a cycle of P+1 ticks. Each output is high while the count is below that channel's compare value, and low for the rest of the cycle. Because both channels use the same counter, their cycle boundaries always line up.

The period and the two compare values are double-buffered. A small sequencer prepares the next set in a buffer, and the active set takes it over only at a counter wrap. When idle, the block runs short cycles with both compares at zero, so both pins stay low. A one-cycle start pulse arms a burst of four cycles:

- Steps 0 and 2 are short cycles with channel A pulsing.
- Steps 1 and 3 are long cycles with channel B pulsing.

After the last step, the idle set is reloaded. A system would trigger this about once per second, with a tick of one microsecond.

Top module: `pwm_burst_seq`

## Requirements
- R1: After reset both outputs, busy and done are low, the counter is 0, the active top count is the short value (119) and both compares are 0.
- R2: The counter increments only on cycles with tick high. When a tick arrives with the count equal to the active top count, it returns to 0. A cycle is therefore top+1 ticks long.
- R3: Each output is high exactly while the shared count is below its compare value. A compare of 0 keeps that output low for the whole cycle.
- R4: Period and compare values change only at a counter wrap, never inside a cycle.
- R5: Burst steps 0 and 2 use top count 119 (120 ticks), with channel A compare 60 and channel B compare 0.
- R6: Burst steps 1 and 3 use top count 7027 (7028 ticks), with channel A compare 0 and channel B compare 600.
- R7: The wrap that ends step 3 loads the idle set: top count 119 and both compares 0. While idle, both outputs stay low.
- R8: A start pulse is ignored while a burst is armed or running, including the wrap that ends step 3. It then causes no extra burst and no extra done pulse.
- R9: A start pulse received while idle arms a burst. Step 0 is loaded at the next wrap. Busy is high from that wrap until the wrap that loads the idle set; with a tick on every clock, that is 14296 clocks.
- R10: Done is high for exactly one clock, the clock right after the wrap that loads the idle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase enable; the counter moves one step when high |
| start | input | 1 | One-cycle burst request |
| pwm_a | output | 1 | Channel A PWM output |
| pwm_b | output | 1 | Channel B PWM output |
| busy | output | 1 | High while a burst step is the active set |
| done | output | 1 | One-clock pulse when a burst has finished |

## Verification
The counter, the active set, busy and done are all registers updated on the same clock edge. A tick or start sampled at one rising edge therefore shows its effect on every output just after that edge. Both PWM outputs are compares taken straight from those registers, so they add no cycle of their own.

The bench drives inputs and checks outputs on the falling edge. At each falling edge it first compares the outputs with its own reference state, then sets the next inputs, then advances that state by exactly one rising edge. A burst that is armed waits for the next wrap, and the reference state models that wait explicitly. Directed runs with a tick on every clock also total the high cycles of each channel and the length of busy.

// File: rtl/pwmseq_pkg.sv
package pwmseq_pkg;

  typedef enum logic [1:0] {
    SLOT_EVEN = 2'd0,
    SLOT_ODD  = 2'd1,
    SLOT_IDLE = 2'd2
  } slot_e;

  // Classifies a schedule index: indexes at or past the step count are idle.
  function automatic slot_e slot_kind(input int unsigned idx, input int unsigned nsteps);
    if (idx >= nsteps) return SLOT_IDLE;
    if (idx[0]) return SLOT_ODD;
    return SLOT_EVEN;
  endfunction

endpackage

// File: rtl/pwmseq_timebase.sv
module pwmseq_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  assign wrap = tick && (cnt == top);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= top);

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(rst)) |-> $stable(cnt));

endmodule

// File: rtl/pwmseq_sched.sv
module pwmseq_sched
  import pwmseq_pkg::*;
#(
  parameter int CW        = 16,
  parameter int NSTEPS    = 4,
  parameter int PER_SHORT = 119,
  parameter int PER_LONG  = 7027,
  parameter int DUTY_A    = 60,
  parameter int DUTY_B    = 600
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wrap,
  output logic [CW-1:0] top_act,
  output logic [CW-1:0] cmp_a,
  output logic [CW-1:0] cmp_b,
  output logic          busy,
  output logic          done
);

  localparam int IW = $clog2(NSTEPS + 1);
  localparam logic [IW-1:0] IDLE = IW'(NSTEPS);
  localparam logic [IW-1:0] LAST = IW'(NSTEPS - 1);

  logic [IW-1:0] act_q, load_q, load_d;
  logic          accept;
  logic          finish_wrap;

  function automatic logic [CW-1:0] top_of(input logic [IW-1:0] i);
    if (slot_kind(int'(i), NSTEPS) == SLOT_ODD) return CW'(PER_LONG);
    return CW'(PER_SHORT);
  endfunction

  function automatic logic [CW-1:0] duty_a_of(input logic [IW-1:0] i);
    if (slot_kind(int'(i), NSTEPS) == SLOT_EVEN) return CW'(DUTY_A);
    return '0;
  endfunction

  function automatic logic [CW-1:0] duty_b_of(input logic [IW-1:0] i);
    if (slot_kind(int'(i), NSTEPS) == SLOT_ODD) return CW'(DUTY_B);
    return '0;
  endfunction

  assign accept      = start && (act_q == IDLE) && (load_q == IDLE);
  assign finish_wrap = wrap && (act_q == LAST);
  assign busy        = (act_q != IDLE);

  always_comb begin
    load_d = load_q;
    if (wrap) begin
      if (load_q == IDLE)      load_d = accept ? '0 : IDLE;
      else if (load_q == LAST) load_d = IDLE;
      else                     load_d = load_q + 1'b1;
    end else if (accept) begin
      load_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= IDLE;
      load_q  <= IDLE;
      top_act <= CW'(PER_SHORT);
      cmp_a   <= '0;
      cmp_b   <= '0;
      done    <= 1'b0;
    end else begin
      load_q <= load_d;
      done   <= finish_wrap;
      if (wrap) begin
        act_q   <= load_q;
        top_act <= top_of(load_q);
        cmp_a   <= duty_a_of(load_q);
        cmp_b   <= duty_b_of(load_q);
      end
    end
  end

  assert_reload_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (top_act != $past(top_act) || cmp_a != $past(cmp_a) || cmp_b != $past(cmp_b)))
      |-> $past(wrap));

  assert_busy_starts_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wrap));

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_idle_values_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cmp_a == '0 && cmp_b == '0 && top_act == CW'(PER_SHORT)));

endmodule

// File: rtl/pwmseq_chan.sv
module pwmseq_chan #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  output logic          pwm
);

  assign pwm = (cnt < cmp);

endmodule

// File: rtl/pwm_burst_seq.sv
module pwm_burst_seq #(
  parameter int CW        = 16,
  parameter int NSTEPS    = 4,
  parameter int PER_SHORT = 119,
  parameter int PER_LONG  = 7027,
  parameter int DUTY_A    = 60,
  parameter int DUTY_B    = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic pwm_a,
  output logic pwm_b,
  output logic busy,
  output logic done
);

  localparam int NCH = 2;

  logic [CW-1:0] cnt, top_act, cmp_a, cmp_b;
  logic          wrap;
  logic [CW-1:0] cmp_arr [NCH];
  logic [NCH-1:0] pwm_v;

  pwmseq_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .top(top_act), .cnt(cnt), .wrap(wrap)
  );

  pwmseq_sched #(
    .CW(CW), .NSTEPS(NSTEPS), .PER_SHORT(PER_SHORT), .PER_LONG(PER_LONG),
    .DUTY_A(DUTY_A), .DUTY_B(DUTY_B)
  ) u_sched (
    .clk(clk), .rst(rst), .start(start), .wrap(wrap),
    .top_act(top_act), .cmp_a(cmp_a), .cmp_b(cmp_b), .busy(busy), .done(done)
  );

  assign cmp_arr[0] = cmp_a;
  assign cmp_arr[1] = cmp_b;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmseq_chan #(.CW(CW)) u_ch (.cnt(cnt), .cmp(cmp_arr[g]), .pwm(pwm_v[g]));
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];

  assert_cycle_start_level_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> (pwm_a == (cmp_a != '0) && pwm_b == (cmp_b != '0)));

endmodule

// File: tb/pwm_burst_seq_test.sv
module pwm_burst_seq_test;

  localparam int SHORT_T = 120;
  localparam int LONG_T  = 7028;
  localparam int DA      = 60;
  localparam int DB      = 600;
  localparam int IDLE_I  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic start = 1'b0;
  logic pwm_a, pwm_b, busy, done;

  int n_vec = 0;
  int n_bad = 0;
  bit summarized = 1'b0;

  // reference state
  int m_cnt, m_top, m_ca, m_cb, m_act, m_load;
  bit m_done;

  always #2 clk = ~clk;

  pwm_burst_seq uut (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .busy(busy), .done(done)
  );

  function automatic int exp_top(input int i);
    return (i < IDLE_I && (i % 2) == 1) ? LONG_T - 1 : SHORT_T - 1;
  endfunction
  function automatic int exp_ca(input int i);
    return (i < IDLE_I && (i % 2) == 0) ? DA : 0;
  endfunction
  function automatic int exp_cb(input int i);
    return (i < IDLE_I && (i % 2) == 1) ? DB : 0;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_top = SHORT_T - 1; m_ca = 0; m_cb = 0;
    m_act = IDLE_I; m_load = IDLE_I; m_done = 1'b0;
  endtask

  task automatic model_edge(input bit t, input bit s);
    bit w, acc;
    w   = t && (m_cnt == m_top);
    acc = s && (m_act == IDLE_I) && (m_load == IDLE_I);
    m_done = w && (m_act == IDLE_I - 1);
    if (w) begin
      m_cnt = 0;
      m_top = exp_top(m_load);
      m_ca  = exp_ca(m_load);
      m_cb  = exp_cb(m_load);
      m_act = m_load;
      if (m_load == IDLE_I)          m_load = acc ? 0 : IDLE_I;
      else if (m_load == IDLE_I - 1) m_load = IDLE_I;
      else                           m_load = m_load + 1;
    end else begin
      if (t) m_cnt = m_cnt + 1;
      if (acc) m_load = 0;
    end
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // Compare outputs (R3 level, R5/R6/R7 via compares, R9 busy, R10 done), then apply one edge.
  task automatic step(input bit t, input bit s);
    chk("R3", "pwm_a", int'(pwm_a), int'(m_cnt < m_ca));
    chk("R3", "pwm_b", int'(pwm_b), int'(m_cnt < m_cb));
    chk("R9", "busy", int'(busy), int'(m_act != IDLE_I));
    chk("R10", "done", int'(done), int'(m_done));
    tick = t; start = s;
    model_edge(t, s);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!summarized) begin
      summarized = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int busy_len, a_hi, b_hi, dones;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "pwm_a", int'(pwm_a), 0);
    chk("R1", "pwm_b", int'(pwm_b), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);

    // R7: idle cycles with ticks keep both outputs low
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0);

    // Directed burst, tick every clock; measure R5, R6, R9 totals and R8 ignoring.
    busy_len = 0; a_hi = 0; b_hi = 0; dones = 0;
    step(1'b1, 1'b1);
    for (int i = 0; i < 15000; i++) begin
      if (busy) busy_len++;
      if (pwm_a) a_hi++;
      if (pwm_b) b_hi++;
      if (done) dones++;
      // R8: start pulses while armed or busy must be ignored
      step(1'b1, (i == 5) || (i == 700) || (i == 9000));
    end
    chk("R9", "busy length", busy_len, 2 * SHORT_T + 2 * LONG_T);
    chk("R5", "channel A high clocks", a_hi, 2 * DA);
    chk("R6", "channel B high clocks", b_hi, 2 * DB);
    chk("R8", "done pulses", dones, 1);

    // R2/R4: stalls in the tick inside a burst; start held high right at the end.
    step(1'b1, 1'b1);
    for (int i = 0; i < 20000; i++) begin
      bit t;
      t = ((i / 37) % 5) != 0;
      step(t, (i > 19000));
    end
    step(1'b1, 1'b0);

    // Random stimulus: sparse ticks and occasional start pulses.
    for (int i = 0; i < 90000; i++) begin
      bit t, s;
      t = ($urandom % 4) != 0;
      s = ($urandom % 2500) == 0;
      step(t, s);
    end

    // Reset in mid-run returns to R1 state.
    rst = 1'b1; tick = 1'b1;
    @(negedge clk);
    rst = 1'b0; tick = 1'b0;
    model_reset();
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0);

    finish_run();
  end

endmodule